// File: doc/BRIEF.md
# Multi-Scheme Serial Line Encoder

This block turns a stream of plain binary data bits into one of four line codes, chosen by a 2-bit scheme select. The four codes are straight level passthrough (NRZ), transition-on-one (NRZI), return-to-zero (RZ) and Manchester. The encoder runs from a clock at twice the bit rate. Each bit period therefore has two half-bit slots. The `half_phase` output marks which slot is current, so the data source can present one bit per period.

The block is a Moore machine. The line output is a flip-flop whose next value depends only on the captured bit, the captured scheme, the stored NRZI level and the slot counter. Input changes inside a clock cycle never reach the line, so the line is free of glitches.

The data bit and the scheme are sampled together at the rising edge that ends a cycle with `half_phase` = 0. The first half of that bit appears on `line_out` during the next cycle, where `half_phase` = 1. The second half appears in the cycle after that, while the source presents the next bit. The line therefore trails the input by one clock.

Top module: `serial_line_encoder`

## Requirements
- R1: While `rst_n` is low, `half_phase` and `line_out` are 0, and the NRZI reference level is cleared to 0. After reset is released, the first NRZI bit of 1 drives the line high.
- R2: `half_phase` is 0 in the first cycle after reset and then alternates on every clock.
- R3: `data_in` and `scheme_sel` are captured only at the edge ending a `half_phase` = 0 cycle. That bit's first half is on `line_out` in the following cycle and its second half in the cycle after. Values presented while `half_phase` = 1 have no effect.
- R4: Scheme 2'b00 (NRZ): the line equals the data bit in both halves.
- R5: Scheme 2'b01 (NRZI): a 1 bit inverts the line level of the previous NRZI bit and a 0 bit keeps it. The level is held through both halves.
- R6: Scheme 2'b10 (RZ), data 1: the line is high in the first half and low in the second.
- R7: Scheme 2'b10 (RZ), data 0: the line is low in both halves.
- R8: Scheme 2'b11 (Manchester): a 0 is sent as high then low, and a 1 as low then high.
- R9: The NRZI reference level changes only on bits encoded in NRZI. It is kept across bits sent in the other schemes.
- R10: `line_out` changes only at the rising clock edge. Input changes inside a cycle do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Serial data bit, presented while `half_phase` = 0 |
| scheme_sel | input | 2 | Line code: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| half_phase | output | 1 | 0 in the bit-capture slot, 1 in the other slot |
| line_out | output | 1 | Registered encoded line level |

## Verification
The assertions assume that data and scheme are only meaningful at the capture edge. They also assume that a bit's mode holds for both of its line halves, which is why they read the captured copies rather than the raw inputs. The stimulus respects this by driving the bit and the scheme at the falling edge of a `half_phase` = 0 cycle. During the following cycle it deliberately drives the inverted data and a different scheme, so those values must be ignored. The sweep covers every 8-bit pattern in each scheme, including all-zero and all-one runs. It then feeds random bits with a random scheme per bit and a dedicated sequence that leaves NRZI and returns to it.

// File: rtl/sle_pkg.sv
package sle_pkg;
  localparam int SCHEME_W = 2;

  typedef enum logic [SCHEME_W-1:0] {
    SCH_NRZ   = 2'b00,
    SCH_NRZI  = 2'b01,
    SCH_RZ    = 2'b10,
    SCH_MANCH = 2'b11
  } scheme_e;

  // Line level for one half-bit slot; late = 1 selects the second half.
  function automatic logic slot_level(scheme_e mode, logic bit_v, logic lvl, logic late);
    logic res;
    case (mode)
      SCH_NRZ:   res = bit_v;
      SCH_NRZI:  res = lvl;
      SCH_RZ:    res = bit_v & ~late;
      default:   res = ~(bit_v ^ late);
    endcase
    return res;
  endfunction
endpackage

// File: rtl/sle_phase_gen.sv
module sle_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic phase_q,
  output logic capture
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign capture = ~phase_q;
endmodule

// File: rtl/sle_bit_latch.sv
module sle_bit_latch
  import sle_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    capture,
  input  logic    data_in,
  input  scheme_e mode_in,
  output logic    bit_q,
  output scheme_e mode_q,
  output logic    lvl_q,
  output logic    lvl_nxt
);
  // NRZI reference advances only on a captured NRZI bit.
  assign lvl_nxt = (capture && mode_in == SCH_NRZI) ? (lvl_q ^ data_in) : lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= 1'b0;
      mode_q <= SCH_NRZ;
      lvl_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt;
      if (capture) begin
        bit_q  <= data_in;
        mode_q <= mode_in;
      end
    end
  end
endmodule

// File: rtl/sle_line_reg.sv
module sle_line_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic level_nxt,
  output logic line_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= level_nxt;
  end
endmodule

// File: rtl/serial_line_encoder.sv
module serial_line_encoder
  import sle_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_in,
  input  logic [SCHEME_W-1:0] scheme_sel,
  output logic                half_phase,
  output logic                line_out
);
  logic    capture;
  logic    bit_q;
  scheme_e mode_q;
  logic    lvl_q;
  logic    lvl_nxt;
  logic    level_nxt;
  scheme_e sel_e;

  assign sel_e = scheme_e'(scheme_sel);

  sle_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_q (half_phase),
    .capture (capture)
  );

  sle_bit_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .data_in (data_in),
    .mode_in (sel_e),
    .bit_q   (bit_q),
    .mode_q  (mode_q),
    .lvl_q   (lvl_q),
    .lvl_nxt (lvl_nxt)
  );

  // First half comes from the fresh inputs, second half from the held bit.
  always_comb begin
    if (capture) level_nxt = slot_level(sel_e, data_in, lvl_nxt, 1'b0);
    else         level_nxt = slot_level(mode_q, bit_q, lvl_q, 1'b1);
  end

  sle_line_reg u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_nxt (level_nxt),
    .line_q    (line_out)
  );
endmodule

// File: rtl/sle_checker.sv
module sle_checker
  import sle_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       half_phase,
  input logic       line_out,
  input logic [1:0] cur_mode,
  input logic       cur_bit,
  input logic       nrzi_lvl
);
  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> half_phase != $past(half_phase)); // R2

  AST_FLAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && (cur_mode == SCH_NRZ || cur_mode == SCH_NRZI)) |-> $stable(line_out)); // R4

  AST_NRZI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_phase && cur_mode == SCH_NRZI && $past(cur_mode) == SCH_NRZI)
      |-> ((line_out != $past(line_out)) == cur_bit)); // R5

  AST_RZ_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && cur_mode == SCH_RZ) |-> !line_out); // R6

  AST_RZ_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == SCH_RZ && !cur_bit) |-> !line_out); // R7

  AST_MAN_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && cur_mode == SCH_MANCH) |-> line_out != $past(line_out)); // R8

  AST_NRZI_REF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nrzi_lvl) |-> cur_mode == SCH_NRZI); // R9

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (!line_out && !half_phase)); // R1
endmodule

bind serial_line_encoder sle_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_phase (half_phase),
  .line_out   (line_out),
  .cur_mode   (mode_q),
  .cur_bit    (bit_q),
  .nrzi_lvl   (lvl_q)
);

// File: tb/serial_line_encoder_tb_top.sv
module serial_line_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_in = 1'b0;
  logic [1:0] scheme_sel = 2'b00;
  logic       half_phase;
  logic       line_out;

  int checks = 0;
  int fails  = 0;
  bit ref_lvl = 1'b0;
  bit exp_sec = 1'b0;
  string sec_tag = "R1";

  always #4 clk = ~clk;

  serial_line_encoder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_in    (data_in),
    .scheme_sel (scheme_sel),
    .half_phase (half_phase),
    .line_out   (line_out)
  );

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge inside a half_phase = 0 cycle; returns at the next one.
  task automatic send(logic [1:0] m, bit b);
    bit f, s;
    string tg;
    check(half_phase, 1'b0, "R2 capture slot");
    check(line_out, exp_sec, {sec_tag, " second half (R3)"});
    scheme_sel = m;
    data_in    = b;
    case (m)
      2'd0: begin f = b; s = b; tg = "R4"; end
      2'd1: begin ref_lvl = ref_lvl ^ b; f = ref_lvl; s = ref_lvl; tg = "R5"; end
      2'd2: begin f = b; s = 1'b0; tg = b ? "R6" : "R7"; end
      default: begin f = ~b; s = b; tg = "R8"; end
    endcase
    @(negedge clk);
    check(half_phase, 1'b1, "R2 second slot");
    check(line_out, f, {tg, " first half"});
    // R3: values in this slot must be ignored; R10: no mid-cycle change.
    data_in    = ~b;
    scheme_sel = ~m;
    #2;
    check(line_out, f, "R10 held within cycle");
    exp_sec = s;
    sec_tag = tg;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(line_out, 1'b0, "R1 line in reset");
      check(half_phase, 1'b0, "R1 phase in reset");
    end
    ref_lvl = 1'b0;
    exp_sec = 1'b0;
    sec_tag = "R1";
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // Exhaustive 8-bit patterns in every scheme, runs of equal bits included.
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 256; p++)
        for (int k = 7; k >= 0; k--)
          send(m[1:0], p[k]);
    // Random bits with a random scheme per bit.
    for (int i = 0; i < 1500; i++)
      send(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    // R1: after a fresh reset the NRZI reference restarts at 0.
    do_reset();
    send(2'd1, 1'b1);
    // R9: reference survives RZ and Manchester bits, then continues.
    send(2'd2, 1'b1);
    send(2'd3, 1'b0);
    send(2'd0, 1'b0);
    send(2'd1, 1'b0);
    send(2'd1, 1'b1);
    send(2'd0, 1'b0);
    check(ref_lvl, 1'b0, "R9 model level");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule